// File: doc/BRIEF.md
# Halfword Signed Adder-Subtractor with Condition Code

This block adds or subtracts two signed two's-complement operands of a parameterised width (16 bits by default) and reports the outcome as a registered result plus a four-bit condition code. The code holds a carry/borrow bit, a signed-overflow bit and a pair of sign bits, one for greater-than-zero and one for less-than-zero, so a zero result shows as both sign bits clear. Each operation comes in a plain form and a with-carry form. The with-carry forms take a carry flag that the block keeps internally and that every accepted operation rewrites.

A multi-word value is handled by issuing the least significant word first with a plain add or subtract. Each more significant word then follows with the matching with-carry form, which picks up the carry or borrow left by the word before it. The operands arrive fully formed, and a caller strobes `valid_i` once per operation. The result and code appear one clock later, together with a one-cycle `done_o` pulse. They stay put until the next accepted operation.

Top module: `hwas_addsub`

## Requirements
- R1: After synchronous active-low reset, `result_o`, `cc_o` and `done_o` are 0 and the stored carry flag is 0, so an add-with-carry of 0 and 0 returns 0.
- R2: `op_i` = 2'b00 (add) yields `result_o` = (A + B) mod 2^W.
- R3: `op_i` = 2'b10 (subtract) yields `result_o` = (A - B) mod 2^W.
- R4: `op_i` = 2'b01 (add with carry) yields (A + B + c) mod 2^W, where c is the stored carry flag.
- R5: `op_i` = 2'b11 (subtract with carry) yields (A - B - c) mod 2^W, where the stored carry flag c acts as a borrow.
- R6: `cc_o[1]` (G) is 1 exactly when the signed result is above zero, and `cc_o[0]` (L) is 1 exactly when it is below zero. Both are 0 for a zero result.
- R7: `cc_o[2]` (V) is 1 exactly when the true signed sum or difference falls outside the signed W-bit range.
- R8: `cc_o[3]` (C) is the carry out of the top bit for the add forms. For the subtract forms it is 1 exactly when the unsigned minuend is smaller than the subtrahend plus any borrow-in.
- R9: The result and code of an operation strobed on one rising edge are visible after that edge, with `done_o` high for exactly that one cycle. `done_o` is 0 in any cycle that does not follow a strobe.
- R10: The stored carry flag takes the C bit of each accepted operation and changes at no other time. The plain forms do not read it.
- R11: With `valid_i` low, `result_o` and `cc_o` keep their previous values.
- R12: A chain of words issued lowest word first (plain form, then with-carry forms) produces the correct multi-word sum or difference, and the final C gives the carry or borrow of the whole chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation select: 00 add, 01 add with carry, 10 subtract, 11 subtract with carry |
| opa_i | input | W | First operand (minuend / addend) |
| opb_i | input | W | Second operand (subtrahend / addend) |
| result_o | output | W | Registered result |
| cc_o | output | 4 | Registered condition code {C, V, G, L} |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench instantiates the block with W = 4. At that width every pair of operands under all four operations can be applied, each one with the stored carry first forced to 0 and then to 1. This places every overflow boundary, every borrow case and every zero and negative-result case under test, and the bench computes the expected values with integer arithmetic. Three-word chains at W = 4 also exercise carry and borrow propagation across a 12-bit value, including wrap-around at the most negative and most positive values.

// File: rtl/hwas_pkg.sv
// Shared types for the halfword adder-subtractor.
// Assumes op bit 1 selects subtract and op bit 0 selects the with-carry form.
package hwas_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_ADDC = 2'b01,
        OP_SUB  = 2'b10,
        OP_SUBC = 2'b11
    } hwas_op_e;

    typedef struct packed {
        logic carry;   // bit 3: carry (add) or borrow (subtract)
        logic ovf;     // bit 2: signed overflow
        logic gt;      // bit 1: result above zero
        logic lt;      // bit 0: result below zero
    } hwas_cc_t;
endpackage

// File: rtl/hwas_core.sv
// Shared adder for add and subtract. A subtract inverts B and turns the
// stored carry into a borrow on the adder's carry input.
// Assumes a purely combinational context; the parent registers the outputs.
module hwas_core
    import hwas_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  hwas_op_e     op_i,
    input  logic         cflag_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o
);
    localparam int EW = W + 1;

    logic         is_sub;
    logic         use_c;
    logic [W-1:0] b_eff;
    logic         cin_bit;
    logic [EW-1:0] wide;

    // Select the operand transform and carry input for the chosen operation.
    always_comb begin
        is_sub  = op_i[1];
        use_c   = op_i[0];
        b_eff   = is_sub ? ~b_i : b_i;
        cin_bit = is_sub ? ~(use_c & cflag_i) : (use_c & cflag_i);
    end

    // One wide addition gives the sum and the raw carry out.
    always_comb begin
        wide  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_bit};
        sum_o = wide[W-1:0];
    end

    // Carry for add, inverted carry (borrow) for subtract; signed overflow.
    always_comb begin
        carry_o = is_sub ? ~wide[W] : wide[W];
        ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/hwas_ccgen.sv
// Builds the condition code from the sum, carry and overflow.
// Assumes the sum is a signed two's-complement value.
module hwas_ccgen
    import hwas_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] sum_i,
    input  logic         carry_i,
    input  logic         ovf_i,
    output hwas_cc_t     cc_o
);
    // Sign bits from the sign bit and a nonzero test; pass the other flags through.
    always_comb begin
        cc_o.carry = carry_i;
        cc_o.ovf   = ovf_i;
        cc_o.lt    = sum_i[W-1];
        cc_o.gt    = ~sum_i[W-1] & (|sum_i);
    end
endmodule

// File: rtl/hwas_addsub.sv
// Top level of the adder-subtractor: the shared adder, the flag builder,
// the output registers and the carry flag used by the with-carry forms.
// Assumes operands arrive fully formed in the cycle valid_i is high.
module hwas_addsub
    import hwas_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W-1:0] result_o,
    output logic [3:0]   cc_o,
    output logic         done_o
);
    logic [W-1:0] sum_d;
    logic         carry_d;
    logic         ovf_d;
    hwas_cc_t     cc_d;
    hwas_cc_t     cc_q;
    logic [W-1:0] result_q;
    logic         done_q;
    logic         carry_q;

    hwas_core #(.W(W)) core_i (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .op_i    (hwas_op_e'(op_i)),
        .cflag_i (carry_q),
        .sum_o   (sum_d),
        .carry_o (carry_d),
        .ovf_o   (ovf_d)
    );

    hwas_ccgen #(.W(W)) ccgen_i (
        .sum_i   (sum_d),
        .carry_i (carry_d),
        .ovf_i   (ovf_d),
        .cc_o    (cc_d)
    );

    // Capture result and code on a strobe; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            cc_q     <= '0;
        end else if (valid_i) begin
            result_q <= sum_d;
            cc_q     <= cc_d;
        end
    end

    // One-cycle completion pulse following each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= valid_i;
    end

    // Stored carry flag: rewritten by every accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n)       carry_q <= 1'b0;
        else if (valid_i) carry_q <= cc_d.carry;
    end

    assign result_o = result_q;
    assign cc_o     = cc_q;
    assign done_o   = done_q;
endmodule

// File: rtl/hwas_addsub_chk.sv
// Property checker for hwas_addsub, attached with bind below.
// Assumes cc bit order {C, V, G, L}.
module hwas_addsub_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_i,
    input logic [W-1:0] result_o,
    input logic [3:0]   cc_o,
    input logic         done_o,
    input logic         carry_q
);
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);                                             // R9
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !done_o);                                           // R9
    AST_SIGN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cc_o[1] && cc_o[0]));                                          // R6
    AST_ZERO_NO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o == '0) |-> (cc_o[1:0] == 2'b00));                      // R6
    AST_LT_TRACKS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        cc_o[0] == result_o[W-1]);                                       // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(result_o) && $stable(cc_o)));              // R11
    AST_CARRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(carry_q));                                  // R10
    AST_CARRY_MATCHES_CC: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (carry_q == cc_o[3]));                                // R10
endmodule

bind hwas_addsub hwas_addsub_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .result_o (result_o),
    .cc_o     (cc_o),
    .done_o   (done_o),
    .carry_q  (carry_q)
);

// File: tb/hwas_addsub_tb_top.sv
module hwas_addsub_tb_top;
    localparam int W  = 4;
    localparam int M  = 1 << W;
    localparam int SH = M / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic [W-1:0] result_o;
    logic [3:0]   cc_o;
    logic         done_o;

    int vecs = 0;
    int miss = 0;
    int mc   = 0;   // model of the stored carry flag

    always #2 clk = ~clk;   // 250 MHz

    hwas_addsub #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o),
        .cc_o(cc_o), .done_o(done_o)
    );

    task automatic chk(input string req, input int got, input int exp);
        vecs++;
        if (got != exp) begin
            miss++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int sgn(input int v);
        return (v >= SH) ? v - M : v;
    endfunction

    // Apply one operation, check the next cycle and the idle cycle after it.
    task automatic apply(input int a, input int b, input int op, output int res);
        int cin, raw, sraw, er, ec, ev, eg, el;
        string tag;
        cin = (op % 2 == 1) ? mc : 0;
        if (op < 2) begin
            raw  = a + b + cin;
            sraw = sgn(a) + sgn(b) + cin;
            ec   = (raw >= M) ? 1 : 0;
        end else begin
            raw  = a - b - cin;
            sraw = sgn(a) - sgn(b) - cin;
            ec   = (raw < 0) ? 1 : 0;
        end
        er = ((raw % M) + M) % M;
        ev = (sraw >= SH || sraw < -SH) ? 1 : 0;
        eg = (sgn(er) > 0) ? 1 : 0;
        el = (sgn(er) < 0) ? 1 : 0;
        case (op)
            0: tag = "R2";
            1: tag = "R4 R10";
            2: tag = "R3";
            default: tag = "R5 R10";
        endcase
        @(negedge clk);
        opa_i = W'(a); opb_i = W'(b); op_i = 2'(op); valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        chk("R9 done", int'(done_o), 1);
        chk(tag, int'(result_o), er);
        chk("R8 carry", int'(cc_o[3]), ec);
        chk("R7 overflow", int'(cc_o[2]), ev);
        chk("R6 greater", int'(cc_o[1]), eg);
        chk("R6 less", int'(cc_o[0]), el);
        mc  = ec;
        res = er;
        opa_i = ~opa_i; opb_i = ~opb_i; op_i = ~op_i;
        @(negedge clk);
        chk("R9 pulse", int'(done_o), 0);
        chk("R11 result", int'(result_o), er);
        chk("R11 cc", int'(cc_o), ec * 8 + ev * 4 + eg * 2 + el);
    endtask

    // Three-word chain, lowest word first; R12.
    task automatic chain(input int x, input int y, input bit sub);
        int r, total, exp, carry_exp, full;
        total = 0;
        for (int w = 0; w < 3; w++) begin
            apply((x >> (w * W)) % M, (y >> (w * W)) % M,
                  (sub ? 2 : 0) + (w > 0 ? 1 : 0), r);
            total += r << (w * W);
        end
        full = sub ? x - y : x + y;
        exp = ((full % (M * M * M)) + M * M * M) % (M * M * M);
        carry_exp = sub ? ((full < 0) ? 1 : 0) : ((full >= M * M * M) ? 1 : 0);
        chk("R12 chain", total, exp);
        chk("R12 carry", int'(cc_o[3]), carry_exp);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miss++;
        $display("FAIL watchdog got 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        int r;
        repeat (3) @(negedge clk);
        chk("R1 result", int'(result_o), 0);
        chk("R1 cc", int'(cc_o), 0);
        chk("R1 done", int'(done_o), 0);
        rst_n = 1'b1;
        apply(0, 0, 1, r);
        chk("R1 carry", r, 0);
        for (int c = 0; c < 2; c++)
            for (int op = 0; op < 4; op++)
                for (int a = 0; a < M; a++)
                    for (int b = 0; b < M; b++) begin
                        apply(c == 1 ? M - 1 : 0, c == 1 ? 1 : 0, 0, r);
                        apply(a, b, op, r);
                    end
        chain(12'h7FF, 12'h001, 1'b0);
        chain(12'hFFF, 12'h001, 1'b0);
        chain(12'h0F8, 12'h00F, 1'b0);
        chain(12'h800, 12'h001, 1'b1);
        chain(12'h000, 12'h001, 1'b1);
        chain(12'h100, 12'h0FF, 1'b1);
        chain(12'h35A, 12'h9C7, 1'b1);
        summary();
        $finish;
    end
endmodule